// File: doc/BRIEF.md
# Stop-Mode Wake-Up Controller

This block sequences a small microcontroller into and out of its deep low-power stop state. The CPU pulses `stop_exec` when it retires a stop instruction. The controller then turns off the CPU clock and the main oscillator enable. If the low-power watchdog mode is configured, it keeps the RC oscillator enabled so that the watchdog can still raise events. Three things end the stop state: a hardware reset, an external interrupt, or an RC watchdog event. Before the CPU clock comes back, a stabilization counter gives the main oscillator time to settle.

There are two exit paths. A reset exit, which is either a hardware reset or a watchdog event with watchdog reset enabled, waits a fixed time that software cannot change. It holds `internal_reset` for that whole time and returns the configuration to its reset value. An interrupt exit keeps the configuration. It counts an 8-bit interval timer from 00h to FFh, clocked by a prescaler that software selects. When the timer overflows, the CPU clock comes back. On that release cycle the controller pulses exactly one of two outputs. It pulses `vector_req` to send the CPU to an interrupt routine, with `vector_sel` naming the source. Otherwise it pulses `resume` to continue at the instruction after the stop instruction.

All pins are plain control and status signals; there is no streamed data. The configuration byte is written through a one-cycle strobe.

Top module: `lpwr_wake_ctrl`

## Requirements
- R1: While `rst_n` is low and for exactly 2^RST_LOG2 cycles after it is released, `internal_reset`=1, `cpu_clk_en`=0 and `main_osc_en`=1. After that, `cpu_clk_en` rises and `internal_reset` falls, with no `vector_req` and no `resume`.
- R2: A configuration write takes effect only when `cfg_wr`=1 and `cfg_byte`=1. A write with `cfg_byte`=0 changes nothing. The fields are: bit 0 RC watchdog mode, bit 1 watchdog reset enable, bits 4:2 divider select k. Bits 7:5 are ignored. All fields reset to 0.
- R3: `stop_exec` while running clears `cpu_clk_en` and `main_osc_en` on the next clock edge. `rc_osc_en` then equals the RC watchdog mode bit for the whole stop state.
- R4: On an interrupt exit, `main_osc_en` rises first. `cpu_clk_en` rises exactly 256·2^(k+3) cycles later. The configuration is kept.
- R5: On an external-interrupt exit with `gie`=1, the release cycle gives a one-cycle `vector_req` with `vector_sel`=0.
- R6: On an interrupt exit with `gie`=0, the release cycle gives a one-cycle `resume` and no `vector_req`.
- R7: A watchdog event in stop with RC mode=1 and watchdog reset enable=0 takes the interrupt path. The release gives `vector_req` with `vector_sel`=1 when `gie`=1 and `wdt_irq_en`=1. Otherwise it gives `resume`.
- R8: A watchdog event in stop with RC mode=1 and watchdog reset enable=1 takes the reset path. `internal_reset` is held for 2^RST_LOG2 cycles and the configuration is cleared.
- R9: Watchdog events are ignored while running, and also in stop when the RC mode bit is 0.
- R10: A wake input that goes high is acted on at the third rising clock edge, through a two-flop synchronizer.
- R11: If a reset-enabled watchdog event and an external interrupt arrive together, the reset path wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Running clock (main or RC source) |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| stop_exec | input | 1 | One-cycle pulse: CPU executed a stop instruction |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_byte | input | 1 | 1 = full byte access, 0 = partial/bit access |
| cfg_wdata | input | BUS_W | Configuration write data |
| gie | input | 1 | Global interrupt enable flag of the CPU |
| wdt_irq_en | input | 1 | Watchdog interrupt enable |
| ext_irq_async | input | 1 | External interrupt wake, asynchronous |
| wdt_evt_async | input | 1 | RC watchdog event, asynchronous |
| cpu_clk_en | output | 1 | CPU clock enable |
| main_osc_en | output | 1 | Main oscillator enable |
| rc_osc_en | output | 1 | RC oscillator enable during stop |
| internal_reset | output | 1 | Internal reset to the core |
| vector_req | output | 1 | One-cycle interrupt vector request |
| vector_sel | output | 1 | Vector source: 0 external, 1 watchdog |
| resume | output | 1 | One-cycle resume-after-stop indication |

## Verification
The bench measures the stabilization window to the exact cycle on both exit paths and at two divider settings. A design that takes the wrong prescaler bits, or leaves the counter off by a power of two, produces a window of the wrong length. It checks a partial-width write and a watchdog event during run or in non-RC stop. A design that honours either of these leaves the RC oscillator enable in the wrong state, or releases the CPU when it should not. It also covers a reset-enabled watchdog event that arrives together with an external interrupt, and the configuration afterwards. Wrong priority shows up as a vector request instead of an internal reset. A missing clear shows up as the RC oscillator staying on in the next stop. The synchronizer delay is pinned to one edge, so a missing or extra stage shifts the oscillator restart.

// File: rtl/lpwr_pkg.sv
package lpwr_pkg;
  localparam int DIV_SEL_W = 3;   // divider select width
  localparam int DIV_BASE  = 3;   // divide = 2^(k + DIV_BASE)
  localparam int ITMR_W    = 8;   // interval timer width

  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_STOP = 2'd1,
    PH_STAB = 2'd2,
    PH_REL  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    WK_NONE   = 2'd0,
    WK_VECTOR = 2'd1,
    WK_RESUME = 2'd2
  } wake_act_e;

  typedef struct packed {
    logic [DIV_SEL_W-1:0] div_sel;
    logic                 wdt_rst_en;
    logic                 rc_mode;
  } lp_cfg_t;

  localparam int CFG_W = $bits(lp_cfg_t);
endpackage

// File: rtl/lpwr_sync.sv
module lpwr_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[0], d_async[i]};
    end
    assign d_sync[i] = sh_q[1];
  end
endmodule

// File: rtl/lpwr_cfg_reg.sv
module lpwr_cfg_reg
  import lpwr_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr,
  input  logic             full,
  input  logic [BUS_W-1:0] wdata,
  output lp_cfg_t          cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg <= '0;
    else if (clear)      cfg <= '0;
    else if (wr && full) cfg <= lp_cfg_t'(wdata[CFG_W-1:0]);
  end

  if (BUS_W > CFG_W) begin : g_rsvd
    logic rsvd_unused;
    assign rsvd_unused = ^wdata[BUS_W-1:CFG_W];
  end
endmodule

// File: rtl/lpwr_stab_timer.sv
module lpwr_stab_timer
  import lpwr_pkg::*;
#(
  parameter int RST_LOG2 = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 fixed,
  input  logic [DIV_SEL_W-1:0] div_sel,
  output logic                 done
);
  localparam int IRQ_MAX = ITMR_W + DIV_BASE + (1 << DIV_SEL_W) - 1;
  localparam int CW      = (RST_LOG2 > IRQ_MAX) ? RST_LOG2 : IRQ_MAX;
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] tmr_q;
  logic [CW-1:0] target;

  // Low bits act as the prescaler, the next ITMR_W bits as the interval timer.
  always_comb begin
    if (fixed) target = (ONE << RST_LOG2) - ONE;
    else       target = (ONE << (32'(div_sel) + DIV_BASE + ITMR_W)) - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tmr_q <= '0;
    else if (!run) tmr_q <= '0;
    else           tmr_q <= tmr_q + ONE;
  end

  assign done = run && (tmr_q == target);
endmodule

// File: rtl/lpwr_wake_ctrl.sv
module lpwr_wake_ctrl
  import lpwr_pkg::*;
#(
  parameter int RST_LOG2 = 18,
  parameter int BUS_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_exec,
  input  logic             cfg_wr,
  input  logic             cfg_byte,
  input  logic [BUS_W-1:0] cfg_wdata,
  input  logic             gie,
  input  logic             wdt_irq_en,
  input  logic             ext_irq_async,
  input  logic             wdt_evt_async,
  output logic             cpu_clk_en,
  output logic             main_osc_en,
  output logic             rc_osc_en,
  output logic             internal_reset,
  output logic             vector_req,
  output logic             vector_sel,
  output logic             resume
);
  phase_e    ph_q, ph_d;
  wake_act_e act_q, act_d;
  logic      rst_path_q, rst_path_d;
  logic      sel_q, sel_d;
  logic      ext_s, wdt_s, wdt_live, cfg_clear, stab_done;
  lp_cfg_t   cfg;

  lpwr_sync #(.W(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({wdt_evt_async, ext_irq_async}),
    .d_sync  ({wdt_s, ext_s})
  );

  lpwr_cfg_reg #(.BUS_W(BUS_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cfg_clear),
    .wr    (cfg_wr),
    .full  (cfg_byte),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  lpwr_stab_timer #(.RST_LOG2(RST_LOG2)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ph_q == PH_STAB),
    .fixed   (rst_path_q),
    .div_sel (cfg.div_sel),
    .done    (stab_done)
  );

  assign wdt_live = cfg.rc_mode && wdt_s;

  always_comb begin
    ph_d       = ph_q;
    act_d      = act_q;
    rst_path_d = rst_path_q;
    sel_d      = sel_q;
    cfg_clear  = 1'b0;
    case (ph_q)
      PH_RUN: if (stop_exec) ph_d = PH_STOP;
      PH_STOP: begin
        if (wdt_live && cfg.wdt_rst_en) begin
          ph_d       = PH_STAB;
          rst_path_d = 1'b1;
          act_d      = WK_NONE;
          sel_d      = 1'b0;
          cfg_clear  = 1'b1;
        end else if (ext_s) begin
          ph_d       = PH_STAB;
          rst_path_d = 1'b0;
          act_d      = gie ? WK_VECTOR : WK_RESUME;
          sel_d      = 1'b0;
        end else if (wdt_live) begin
          ph_d       = PH_STAB;
          rst_path_d = 1'b0;
          act_d      = (gie && wdt_irq_en) ? WK_VECTOR : WK_RESUME;
          sel_d      = 1'b1;
        end
      end
      PH_STAB: if (stab_done) ph_d = PH_REL;
      default: ph_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q           <= PH_STAB;
      act_q          <= WK_NONE;
      rst_path_q     <= 1'b1;
      sel_q          <= 1'b0;
      cpu_clk_en     <= 1'b0;
      main_osc_en    <= 1'b1;
      rc_osc_en      <= 1'b0;
      internal_reset <= 1'b1;
      vector_req     <= 1'b0;
      vector_sel     <= 1'b0;
      resume         <= 1'b0;
    end else begin
      ph_q           <= ph_d;
      act_q          <= act_d;
      rst_path_q     <= rst_path_d;
      sel_q          <= sel_d;
      cpu_clk_en     <= (ph_d == PH_RUN) || (ph_d == PH_REL);
      main_osc_en    <= (ph_d != PH_STOP);
      rc_osc_en      <= (ph_d == PH_STOP) && cfg.rc_mode;
      internal_reset <= (ph_d == PH_STAB) && rst_path_d;
      vector_req     <= (ph_d == PH_REL) && (act_d == WK_VECTOR);
      vector_sel     <= (ph_d == PH_REL) && (act_d == WK_VECTOR) && sel_d;
      resume         <= (ph_d == PH_REL) && (act_d == WK_RESUME);
    end
  end
endmodule

// File: rtl/lpwr_wake_chk.sv
module lpwr_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_exec,
  input logic       cpu_clk_en,
  input logic       main_osc_en,
  input logic       rc_osc_en,
  input logic       internal_reset,
  input logic       vector_req,
  input logic       resume,
  input logic [1:0] ph
);
  // R3
  stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd0 && stop_exec) |=> (!cpu_clk_en && !main_osc_en));
  // R1
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    internal_reset |-> (!cpu_clk_en && main_osc_en));
  // R4
  clk_after_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> $past(main_osc_en));
  // R6
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vector_req && resume));
  // R5
  vec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vector_req |=> !vector_req);
  // R3
  rc_only_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rc_osc_en |-> (!main_osc_en && !cpu_clk_en));
  // R6
  resume_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (cpu_clk_en && !internal_reset));
endmodule

bind lpwr_wake_ctrl lpwr_wake_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .stop_exec      (stop_exec),
  .cpu_clk_en     (cpu_clk_en),
  .main_osc_en    (main_osc_en),
  .rc_osc_en      (rc_osc_en),
  .internal_reset (internal_reset),
  .vector_req     (vector_req),
  .resume         (resume),
  .ph             (ph_q)
);

// File: tb/sim_lpwr_wake_ctrl.sv
`timescale 1ns/1ps
module sim_lpwr_wake_ctrl;
  localparam int RLOG = 8;
  localparam int RST_N_CYC = 1 << RLOG;

  logic clk = 1'b0;
  logic rst_n, stop_exec, cfg_wr, cfg_byte, gie, wdt_irq_en, ext_a, wdt_a;
  logic [7:0] cfg_wdata;
  logic cpu_clk_en, main_osc_en, rc_osc_en, internal_reset, vector_req, vector_sel, resume;

  int n_run = 0;
  int n_fail = 0;
  bit done_flag = 0;

  typedef struct { int kind; bit sel; string req; } exp_t; // kind 0 vector, 1 resume, 2 internal reset
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  lpwr_wake_ctrl #(.RST_LOG2(RLOG), .BUS_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .stop_exec(stop_exec), .cfg_wr(cfg_wr), .cfg_byte(cfg_byte),
    .cfg_wdata(cfg_wdata), .gie(gie), .wdt_irq_en(wdt_irq_en), .ext_irq_async(ext_a),
    .wdt_evt_async(wdt_a), .cpu_clk_en(cpu_clk_en), .main_osc_en(main_osc_en),
    .rc_osc_en(rc_osc_en), .internal_reset(internal_reset), .vector_req(vector_req),
    .vector_sel(vector_sel), .resume(resume)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input bit sel, input string req);
    exp_t e;
    e.kind = kind; e.sel = sel; e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: compares observed release/reset events against the queue
  logic ir_prev = 1'b0;
  task automatic pop_cmp(input int kind, input bit sel);
    exp_t e;
    if (exp_q.size() == 0) begin
      chk(0, "R9", "unexpected event kind", kind, -1);
    end else begin
      e = exp_q.pop_front();
      chk(e.kind == kind, e.req, "event kind", kind, e.kind);
      if (kind == 0) chk(e.sel == sel, e.req, "vector_sel", int'(sel), int'(e.sel));
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (vector_req) pop_cmp(0, vector_sel);
      if (resume) pop_cmp(1, 1'b0);
      if (internal_reset && !ir_prev) pop_cmp(2, 1'b0);
    end
    ir_prev = internal_reset;
  end

  task automatic wcfg(input bit full, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_byte = full; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0; cfg_byte = 1'b0;
  endtask

  task automatic go_stop(input bit rc_exp, input string req);
    @(negedge clk); stop_exec = 1'b1;
    @(negedge clk); stop_exec = 1'b0;
    chk(!cpu_clk_en && !main_osc_en, "R3", "clock/osc off in stop", int'(cpu_clk_en), 0);
    chk(rc_osc_en == rc_exp, req, "rc_osc_en in stop", int'(rc_osc_en), int'(rc_exp));
  endtask

  task automatic wake(input bit e, input bit w, output int n);
    @(negedge clk); ext_a = e; wdt_a = w;
    @(posedge clk); @(posedge clk); #1;
    chk(main_osc_en == 1'b0, "R10", "osc before third edge", int'(main_osc_en), 0);
    @(posedge clk); #1;
    chk(main_osc_en == 1'b1, "R10", "osc at third edge", int'(main_osc_en), 1);
    ext_a = 1'b0; wdt_a = 1'b0;
    n = 0;
    while (!cpu_clk_en) begin @(posedge clk); #1; n++; end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; stop_exec = 0; cfg_wr = 0; cfg_byte = 0; cfg_wdata = '0;
    gie = 0; wdt_irq_en = 0; ext_a = 0; wdt_a = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(internal_reset && !cpu_clk_en && main_osc_en, "R1", "reset outputs", int'(internal_reset), 1);
    chk(!vector_req && !resume, "R1", "no outcome in reset", int'(vector_req), 0);
    rst_n = 1'b1;
    n = 0;
    while (!cpu_clk_en) begin @(posedge clk); #1; n++; end
    chk(n >= RST_N_CYC && n <= RST_N_CYC + 2, "R1", "reset stabilization cycles", n, RST_N_CYC);
    chk(!internal_reset, "R1", "internal_reset released", int'(internal_reset), 0);
    repeat (3) @(negedge clk);

    // R5: external wake, gie=1, k=0
    wcfg(1'b1, 8'h01); gie = 1; wdt_irq_en = 1;
    go_stop(1'b1, "R2");
    push(0, 1'b0, "R5");
    wake(1'b1, 1'b0, n);
    chk(n >= 2048 && n <= 2050, "R4", "interrupt stabilization k=0", n, 2048);
    chk(exp_q.size() == 0, "R5", "vector seen", exp_q.size(), 0);

    // R2 partial write ignored; R4 config kept; R7 watchdog vector
    wcfg(1'b0, 8'h00);
    go_stop(1'b1, "R2");
    push(0, 1'b1, "R7");
    wake(1'b0, 1'b1, n);
    chk(n >= 2048 && n <= 2050, "R7", "watchdog wake stabilization", n, 2048);

    // R7 watchdog interrupt disabled -> resume
    wdt_irq_en = 0;
    go_stop(1'b1, "R4");
    push(1, 1'b0, "R7");
    wake(1'b0, 1'b1, n);
    chk(exp_q.size() == 0, "R7", "resume seen", exp_q.size(), 0);

    // R9 watchdog ignored while running
    @(negedge clk); wdt_a = 1'b1;
    repeat (10) @(negedge clk);
    chk(cpu_clk_en && main_osc_en, "R9", "run unaffected by watchdog", int'(cpu_clk_en), 1);
    wdt_a = 1'b0;
    repeat (3) @(negedge clk);

    // R9 watchdog ignored in non-RC stop; R6 resume; R4 k=1
    wcfg(1'b1, 8'h04); gie = 0;
    go_stop(1'b0, "R2");
    @(negedge clk); wdt_a = 1'b1;
    repeat (10) @(negedge clk);
    chk(!main_osc_en && !cpu_clk_en, "R9", "still stopped after watchdog", int'(main_osc_en), 0);
    wdt_a = 1'b0;
    repeat (3) @(negedge clk);
    push(1, 1'b0, "R6");
    wake(1'b1, 1'b0, n);
    chk(n >= 4096 && n <= 4098, "R4", "interrupt stabilization k=1", n, 4096);

    // R8/R11 reset-enabled watchdog together with external interrupt
    wcfg(1'b1, 8'h07); gie = 1; wdt_irq_en = 1;
    go_stop(1'b1, "R2");
    push(2, 1'b0, "R11");
    wake(1'b1, 1'b1, n);
    chk(n >= RST_N_CYC && n <= RST_N_CYC + 2, "R8", "watchdog reset stabilization", n, RST_N_CYC);
    chk(!internal_reset, "R8", "internal_reset released", int'(internal_reset), 0);
    go_stop(1'b0, "R8");
    push(0, 1'b0, "R8");
    wake(1'b1, 1'b0, n);
    chk(n >= 2048 && n <= 2050, "R8", "divider cleared after reset path", n, 2048);

    chk(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule